// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software programs it through a small byte-wide register port. A control byte carries an enable, a start/busy bit and a channel number. A configuration byte carries the result alignment, the conversion-clock divider and the completion flag. Two further bytes hold the result. The block divides the system clock into a conversion clock. On a start it holds the sampled input and walks trial codes from the most significant bit down, using an external comparator. It then stores the code in the two result bytes and raises a sticky completion flag.

Software can cancel a conversion by writing the start bit back to zero. The stored result is left untouched. The sequencer then waits two conversion-clock periods before it reconnects the input for acquisition. The sample-and-hold, the DAC and the comparator sit outside the block. They are reached through a hold output, a trial-code output and a comparator input.

Top module: `sar_seq`

## Requirements
- R1: After reset every output reads zero: hold, acquire, busy, flag, channel, trial code and both result bytes.
- R2: The conversion clock period is (2 << sel) system clocks, where sel is config bits 2:1 (sel = 2 gives divide-by-8). hold_o stays high for exactly 11 such periods per completed conversion.
- R3: hold_o rises on the first conversion-clock tick after the start has taken effect. This is between 2 and (2 << sel) + 1 clock edges after the edge that accepts the start write.
- R4: trial_code is zero outside the hold window and during the first hold period. During hold period k (k = 2..11), it shows the bits above bit 11-k already resolved, with bit 11-k set to 1 and all lower bits 0. At the end of each such period the trial bit is cleared if cmp_in = 1 (trial above input). The final code equals the input code.
- R5: On the edge that ends hold period 11, the following all happen together: the result bytes load, go_o falls, flag_o rises and hold_o falls.
- R6: Config bit 0 selects the alignment. With 0, res_hi = {6'b0, code[9:8]} and res_lo = code[7:0]. With 1, res_hi = code[9:2] and res_lo = {code[1:0], 6'b0}. The bit in force at completion applies.
- R7: A control write with enable = 1 and start = 0 during a pending or running conversion aborts it. hold_o falls on the next edge, and the result bytes and flag_o keep their values.
- R8: After an abort, acq_o stays low for two conversion-clock ticks and then rises. A start written during this wait is ignored.
- R9: A start bit written in the same control write that switches the block from disabled to enabled is ignored.
- R10: Writes to address 2 (low byte) and address 3 (high byte) set res_lo and res_hi. The values persist until a conversion completes.
- R11: flag_o stays set until software writes config bit 7 as 0. An aborted conversion never sets it.
- R12: The control byte at address 0 holds enable (bit 0), start (bit 1) and channel (bits 5:2, shown on chan_o). Clearing enable stops any activity at once: go_o is 0 and the result bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 config, 2 result low, 3 result high |
| wr_data | input | 8 | Write data |
| cmp_in | input | 1 | Comparator: 1 when trial voltage exceeds held input |
| trial_code | output | RES_W | Code driven to the DAC |
| hold_o | output | 1 | High while the input is disconnected and held |
| acq_o | output | 1 | High while the input is connected for acquisition |
| go_o | output | 1 | Start/busy bit |
| flag_o | output | 1 | Sticky completion flag |
| chan_o | output | CH_W | Selected analog channel |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |

## Verification
A write takes effect on the edge after its strobe is driven. Register-side results therefore show one cycle after the strobe: channel, flag, written result bytes and the start bit. Effects that pass through the sequencer state show one edge later. This covers hold falling on abort, and acquire falling on disable or abort. Hold rises only on a conversion-clock tick. It then stays high for exactly 11 ticks, and the result, busy and flag outputs change on that last tick. A behavioural model in the bench tracks the divider phase and each write, and it is compared with every output at each falling edge. Directed checks measure the start-to-hold window, the hold length and the recovery length in counted clock edges.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_CONV  = 2'd2,
        ST_RECOV = 2'd3
    } seq_state_e;

    localparam int unsigned BYTE_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_RLO  = 2'd2;
    localparam logic [1:0] ADDR_RHI  = 2'd3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_GO_BIT  = 1;
    localparam int CTRL_CH_LSB  = 2;
    localparam int CFG_LEFT_BIT = 0;
    localparam int CFG_SEL_LSB  = 1;
    localparam int CFG_FLAG_BIT = 7;

endpackage

// File: rtl/sar_seq_tad_div.sv
module sar_seq_tad_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int MAX_DIV = 2 << ((1 << SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t d, q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim    = CNT_W'((32'd2 << sel_i) - 32'd1);
        tick_o = run_i && (q.cnt >= lim);
        d      = q;
        if (!run_i || tick_o) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: ticks are separated by at least two system clocks
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int RECOV_TADS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             go_i,
    input  logic             tick_i,
    input  logic             cmp_i,
    output logic             ready_o,
    output logic             hold_o,
    output logic             acq_o,
    output logic [RES_W-1:0] trial_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int TADS  = RES_W + 1;
    localparam int TAD_W = $clog2(TADS + 1);
    localparam int RC_W  = (RECOV_TADS > 1) ? $clog2(RECOV_TADS) : 1;

    typedef struct packed {
        seq_state_e       state;
        logic [TAD_W-1:0] tad;
        logic [RES_W-1:0] sar;
        logic [RC_W-1:0]  rc;
    } fsm_t;

    fsm_t d, q;
    logic [RES_W-1:0] resolved;
    int               idx;

    // next trial word: settle the current bit, arm the one below
    always_comb begin
        idx      = TADS - int'(q.tad);
        resolved = q.sar;
        for (int b = 0; b < RES_W; b++) begin
            if (b == idx && cmp_i) begin
                resolved[b] = 1'b0;
            end
            if (b + 1 == idx) begin
                resolved[b] = 1'b1;
            end
        end
    end

    always_comb begin
        d      = q;
        done_o = 1'b0;
        if (!en_i) begin
            d.state = ST_IDLE;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    if (go_i) begin
                        d.state = ST_SYNC;
                    end
                end
                ST_SYNC: begin
                    if (!go_i) begin
                        d.state = ST_RECOV;
                        d.rc    = '0;
                    end else if (tick_i) begin
                        d.state = ST_CONV;
                        d.tad   = TAD_W'(1);
                        d.sar   = '0;
                    end
                end
                ST_CONV: begin
                    if (!go_i) begin
                        d.state = ST_RECOV;
                        d.rc    = '0;
                    end else if (tick_i) begin
                        if (q.tad == TAD_W'(1)) begin
                            d.sar = {1'b1, {(RES_W-1){1'b0}}};
                        end else begin
                            d.sar = resolved;
                        end
                        d.tad = q.tad + 1'b1;
                        if (q.tad == TAD_W'(TADS)) begin
                            done_o  = 1'b1;
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_RECOV: begin
                    if (tick_i) begin
                        if (q.rc == RC_W'(RECOV_TADS - 1)) begin
                            d.state = ST_IDLE;
                        end else begin
                            d.rc = q.rc + 1'b1;
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    assign result_o = resolved;
    assign ready_o  = (q.state == ST_IDLE);
    assign hold_o   = (q.state == ST_CONV);
    assign acq_o    = en_i && ((q.state == ST_IDLE) || (q.state == ST_SYNC));
    assign trial_o  = hold_o ? q.sar : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R4: trial word only moves on a conversion-clock tick
    a_r4_sar_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(q.sar));

    // R7: a busy sequencer that loses its start bit goes to recovery
    a_r7_abort_to_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_SYNC || q.state == ST_CONV) && en_i && !go_i)
            |=> (q.state == ST_RECOV));

    // R8: the start bit cannot be set while recovering
    a_r8_no_start_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_RECOV) |-> !go_i);

    // R2: period counter stays inside the 11 hold periods
    a_r2_tad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_CONV) |-> (q.tad >= TAD_W'(1) && q.tad <= TAD_W'(TADS)));

endmodule

// File: rtl/sar_seq_fmt.sv
module sar_seq_fmt
    import sar_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0]  raw_i,
    input  logic              left_i,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o
);
    localparam int PAD = 2 * BYTE_W - RES_W;

    logic [2*BYTE_W-1:0] pair;

    generate
        if (PAD == 0) begin : g_full
            assign pair = raw_i;
        end else begin : g_pad
            always_comb begin
                if (left_i) begin
                    pair = {raw_i, {PAD{1'b0}}};
                end else begin
                    pair = {{PAD{1'b0}}, raw_i};
                end
            end
        end
    endgenerate

    assign hi_o = pair[2*BYTE_W-1:BYTE_W];
    assign lo_o = pair[BYTE_W-1:0];

endmodule

// File: rtl/sar_seq_regs.sv
module sar_seq_regs
    import sar_seq_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              ready_i,
    input  logic              done_i,
    input  logic [BYTE_W-1:0] load_hi_i,
    input  logic [BYTE_W-1:0] load_lo_i,
    output logic              en_o,
    output logic              go_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              left_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              flag_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o
);
    typedef struct packed {
        logic              en;
        logic              go;
        logic [CH_W-1:0]   chan;
        logic              left;
        logic [SEL_W-1:0]  sel;
        logic              flag;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d = q;
        if (wr_i) begin
            case (addr_i)
                ADDR_CTRL: begin
                    d.en   = wdata_i[CTRL_EN_BIT];
                    d.chan = wdata_i[CTRL_CH_LSB +: CH_W];
                    if (!wdata_i[CTRL_EN_BIT] || !wdata_i[CTRL_GO_BIT]) begin
                        d.go = 1'b0;
                    end else if (q.en && ready_i) begin
                        d.go = 1'b1;
                    end
                end
                ADDR_CFG: begin
                    d.left = wdata_i[CFG_LEFT_BIT];
                    d.sel  = wdata_i[CFG_SEL_LSB +: SEL_W];
                    d.flag = wdata_i[CFG_FLAG_BIT];
                end
                ADDR_RLO: d.lo = wdata_i;
                ADDR_RHI: d.hi = wdata_i;
                default: ;
            endcase
        end
        if (done_i) begin
            d.go   = 1'b0;
            d.flag = 1'b1;
            d.hi   = load_hi_i;
            d.lo   = load_lo_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign en_o   = q.en;
    assign go_o   = q.go;
    assign chan_o = q.chan;
    assign left_o = q.left;
    assign sel_o  = q.sel;
    assign flag_o = q.flag;
    assign hi_o   = q.hi;
    assign lo_o   = q.lo;

    // R9: start can only rise when the block was already enabled
    a_r9_start_needs_prior_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.go) |-> $past(q.en));

    // R5: completion clears start and raises the flag
    a_r5_done_updates: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (!q.go && q.flag));

    // R11: the flag only drops through a config write
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !(wr_i && addr_i == ADDR_CFG)) |=> q.flag);

    // R10: result bytes change only by completion or a result write
    a_r10_result_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !(wr_i && addr_i[1])) |=> $stable({q.hi, q.lo}));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int CH_W       = 4,
    parameter int SEL_W      = 2,
    parameter int RECOV_TADS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  trial_code,
    output logic              hold_o,
    output logic              acq_o,
    output logic              go_o,
    output logic              flag_o,
    output logic [CH_W-1:0]   chan_o,
    output logic [7:0]        res_hi,
    output logic [7:0]        res_lo
);
    logic              en, ready, tick, done, left;
    logic [SEL_W-1:0]  sel;
    logic [RES_W-1:0]  result;
    logic [BYTE_W-1:0] load_hi, load_lo;

    sar_seq_regs #(.CH_W(CH_W), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en),
        .addr_i   (wr_addr),
        .wdata_i  (wr_data),
        .ready_i  (ready),
        .done_i   (done),
        .load_hi_i(load_hi),
        .load_lo_i(load_lo),
        .en_o     (en),
        .go_o     (go_o),
        .chan_o   (chan_o),
        .left_o   (left),
        .sel_o    (sel),
        .flag_o   (flag_o),
        .hi_o     (res_hi),
        .lo_o     (res_lo)
    );

    sar_seq_tad_div #(.SEL_W(SEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (en),
        .sel_i (sel),
        .tick_o(tick)
    );

    sar_seq_fsm #(.RES_W(RES_W), .RECOV_TADS(RECOV_TADS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .go_i    (go_o),
        .tick_i  (tick),
        .cmp_i   (cmp_in),
        .ready_o (ready),
        .hold_o  (hold_o),
        .acq_o   (acq_o),
        .trial_o (trial_code),
        .done_o  (done),
        .result_o(result)
    );

    sar_seq_fmt #(.RES_W(RES_W)) u_fmt (
        .raw_i (result),
        .left_i(left),
        .hi_o  (load_hi),
        .lo_o  (load_lo)
    );

endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
    localparam int RES_W = 10;
    localparam int CH_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [7:0]       wr_data = 8'd0;
    logic             cmp_in;
    logic [RES_W-1:0] trial_code;
    logic             hold_o, acq_o, go_o, flag_o;
    logic [CH_W-1:0]  chan_o;
    logic [7:0]       res_hi, res_lo;

    int analog = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    assign cmp_in = (int'(trial_code) > analog);

    always #5 clk = ~clk;

    sar_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_in(cmp_in), .trial_code(trial_code),
        .hold_o(hold_o), .acq_o(acq_o), .go_o(go_o), .flag_o(flag_o),
        .chan_o(chan_o), .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    // phase: 0 idle, 1 waiting for tick, 2 holding, 3 recovering
    int  m_phase, m_div, m_period, m_wait, m_chan, m_sel, m_hi, m_lo;
    bit  m_en, m_go, m_left, m_flag;

    function automatic int exp_trial();
        if (m_phase != 2 || m_period < 2) return 0;
        return ((analog >> (12 - m_period)) << (12 - m_period)) | (1 << (11 - m_period));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_div = 0; m_period = 0; m_wait = 0; m_chan = 0;
            m_sel = 0; m_hi = 0; m_lo = 0; m_en = 0; m_go = 0; m_left = 0; m_flag = 0;
        end else begin
            bit tick, fin;
            int nphase, code;
            tick = m_en && (m_div + 1 >= (2 << m_sel));
            fin = 1'b0;
            nphase = m_phase;
            code = analog;
            if (!m_en) nphase = 0;
            else if (m_phase == 0) begin
                if (m_go) nphase = 1;
            end else if (m_phase == 1 || m_phase == 2) begin
                if (!m_go) begin nphase = 3; m_wait = 0; end
                else if (tick && m_phase == 1) begin nphase = 2; m_period = 1; end
                else if (tick) begin
                    if (m_period == 11) begin fin = 1'b1; nphase = 0; end
                    m_period++;
                end
            end else if (tick) begin
                m_wait++;
                if (m_wait == 2) nphase = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_chan = int'(wr_data[5:2]);
                        if (!wr_data[0] || !wr_data[1]) m_go = 0;
                        else if (m_en && m_phase == 0) m_go = 1;
                        m_en = wr_data[0];
                    end
                    2'd1: begin
                        m_left = wr_data[0]; m_sel = int'(wr_data[2:1]); m_flag = wr_data[7];
                    end
                    2'd2: m_lo = int'(wr_data);
                    default: m_hi = int'(wr_data);
                endcase
            end
            if (fin) begin
                m_go = 0; m_flag = 1;
                if (m_left) begin m_hi = code >> 2; m_lo = (code & 3) << 6; end
                else begin m_hi = code >> 8; m_lo = code & 255; end
            end
            m_div = (tick || !m_en_prev_guard(tick)) ? 0 : m_div + 1;
            m_phase = nphase;
        end
    end

    // divider restarts whenever the enable seen at this edge was low
    bit m_en_d;
    always @(posedge clk) m_en_d <= rst_n ? m_en : 1'b0;
    function automatic bit m_en_prev_guard(input bit t);
        return m_en_d || t;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(hold_o === (m_phase == 2), "R3 hold_o", int'(hold_o), int'(m_phase == 2));
            chk(int'(trial_code) == exp_trial(), "R4 trial_code", int'(trial_code), exp_trial());
            chk(go_o === m_go, "R5 go_o", int'(go_o), int'(m_go));
            chk(flag_o === m_flag, "R11 flag_o", int'(flag_o), int'(m_flag));
            chk(int'(res_hi) == m_hi && int'(res_lo) == m_lo, "R6 result bytes",
                int'({res_hi, res_lo}), (m_hi << 8) | m_lo);
            chk(acq_o === (m_en && (m_phase == 0 || m_phase == 1)), "R8 acq_o",
                int'(acq_o), int'(m_en && (m_phase == 0 || m_phase == 1)));
            chk(int'(chan_o) == m_chan, "R12 chan_o", int'(chan_o), m_chan);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input bit en, input bit go, input int ch);
        return {2'b00, 4'(ch), go, en};
    endfunction

    function automatic logic [7:0] cfg(input bit flag, input int sel, input bit left);
        return {flag, 4'b0000, 2'(sel), left};
    endfunction

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (go_o && n < 600) begin @(negedge clk); n++; end
        chk(!go_o, tag, int'(go_o), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n, m;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(!hold_o && !acq_o && !go_o && !flag_o, "R1 control outputs",
            int'({hold_o, acq_o, go_o, flag_o}), 0);
        chk(res_hi == 8'd0 && res_lo == 8'd0 && trial_code == '0 && chan_o == '0,
            "R1 data outputs", int'({res_hi, res_lo}), 0);
        @(posedge clk); #2; rst_n = 1'b1;

        // configure divide-by-8, right aligned; enable on channel 3
        wr(2'd1, cfg(1'b0, 2, 1'b0));
        wr(2'd0, ctl(1'b1, 1'b0, 3));
        @(negedge clk);
        chk(chan_o == 4'd3, "R12 channel shown", int'(chan_o), 3);

        // first conversion, measure start window and hold length
        analog = 'h2A5;
        wr(2'd0, ctl(1'b1, 1'b1, 3));
        n = 0;
        while (!hold_o && n < 50) begin @(negedge clk); n++; end
        chk(n >= 2 && n <= 9, "R3 start to hold edges", n, 9);
        m = 0;
        while (hold_o && m < 200) begin @(negedge clk); m++; end
        chk(m == 88, "R2 hold length div8", m, 88);
        chk(!go_o && flag_o, "R5 done state", int'({go_o, flag_o}), 1);
        chk(res_hi == 8'h02 && res_lo == 8'hA5, "R6 right aligned", int'({res_hi, res_lo}), 'h02A5);

        // left aligned, flag kept set by the write
        wr(2'd1, cfg(1'b1, 2, 1'b1));
        wr(2'd0, ctl(1'b1, 1'b1, 3));
        wait_idle("R5 left conversion ends");
        chk(res_hi == 8'hA9 && res_lo == 8'h40, "R6 left aligned", int'({res_hi, res_lo}), 'hA940);

        // flag clear by software
        wr(2'd1, cfg(1'b0, 0, 1'b0));
        @(negedge clk);
        chk(!flag_o, "R11 flag cleared", int'(flag_o), 0);

        // boundaries at divide-by-2
        analog = 0;
        wr(2'd0, ctl(1'b1, 1'b1, 1));
        n = 0;
        while (!hold_o && n < 50) begin @(negedge clk); n++; end
        m = 0;
        while (hold_o && m < 200) begin @(negedge clk); m++; end
        chk(m == 22, "R2 hold length div2", m, 22);
        chk(res_hi == 8'h00 && res_lo == 8'h00, "R4 code zero", int'({res_hi, res_lo}), 0);
        analog = 1023;
        wr(2'd0, ctl(1'b1, 1'b1, 1));
        wait_idle("R5 full scale ends");
        chk(res_hi == 8'h03 && res_lo == 8'hFF, "R4 code full scale", int'({res_hi, res_lo}), 'h03FF);

        // software-written result persists, then abort keeps it
        wr(2'd1, cfg(1'b0, 2, 1'b0));
        wr(2'd2, 8'h5A);
        wr(2'd3, 8'h3C);
        repeat (30) @(negedge clk);
        chk(res_hi == 8'h3C && res_lo == 8'h5A, "R10 written bytes persist", int'({res_hi, res_lo}), 'h3C5A);
        analog = 'h155;
        wr(2'd0, ctl(1'b1, 1'b1, 2));
        n = 0;
        while (!hold_o && n < 50) begin @(negedge clk); n++; end
        repeat (20) @(negedge clk);
        wr(2'd0, ctl(1'b1, 1'b0, 2));
        @(negedge clk);
        @(negedge clk);
        chk(!hold_o && !go_o, "R7 abort releases hold", int'({hold_o, go_o}), 0);
        chk(res_hi == 8'h3C && res_lo == 8'h5A, "R7 result kept on abort", int'({res_hi, res_lo}), 'h3C5A);
        chk(!flag_o, "R11 no flag on abort", int'(flag_o), 0);
        chk(!acq_o, "R8 no acquisition while recovering", int'(acq_o), 0);
        wr(2'd0, ctl(1'b1, 1'b1, 2));
        @(negedge clk);
        chk(!go_o, "R8 start ignored in recovery", int'(go_o), 0);
        n = 0;
        while (!acq_o && n < 40) begin @(negedge clk); n++; end
        chk(acq_o && n <= 17, "R8 acquisition resumes", n, 17);

        // start in the enabling write is ignored
        wr(2'd0, ctl(1'b0, 1'b0, 0));
        wr(2'd0, ctl(1'b1, 1'b1, 5));
        @(negedge clk);
        chk(!go_o, "R9 start with enable ignored", int'(go_o), 0);
        m = 0;
        repeat (40) begin @(negedge clk); if (hold_o) m++; end
        chk(m == 0, "R9 no hold after ignored start", m, 0);

        // disable mid-conversion
        analog = 'h0F0;
        wr(2'd0, ctl(1'b1, 1'b1, 5));
        n = 0;
        while (!hold_o && n < 50) begin @(negedge clk); n++; end
        repeat (10) @(negedge clk);
        wr(2'd0, ctl(1'b0, 1'b1, 5));
        @(negedge clk);
        @(negedge clk);
        chk(!go_o && !hold_o && !acq_o, "R12 disable stops", int'({go_o, hold_o, acq_o}), 0);
        chk(res_hi == 8'h3C && res_lo == 8'h5A, "R12 result kept on disable", int'({res_hi, res_lo}), 'h3C5A);

        // recovery to a normal conversion
        wr(2'd0, ctl(1'b1, 1'b0, 5));
        wr(2'd0, ctl(1'b1, 1'b1, 5));
        wait_idle("R5 final conversion ends");
        chk(res_hi == 8'h00 && res_lo == 8'hF0 && flag_o, "R5 final result", int'({res_hi, res_lo}), 'h00F0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule